// File: doc/BRIEF.md
# Wake Event History Logger

This block keeps a black-box history of the most recent wake and reset events in a small circular store. A capture strobe carries the event source and the power mode on each side of the transition. The block adds a sequence number and a timestamp, and writes all five fields as a single record in one clock edge. The timestamp comes from a free-running counter that starts at zero when reset is released.

A host reads the history oldest-first. The oldest stored record is always presented on the read port, together with the number of stored records. A pop strobe discards that record and exposes the next one.

When the store is full and a new event arrives, the oldest record is sacrificed. A sticky overflow flag and a lost-record counter report the loss. The sequence number keeps counting across every capture, so a reader sees a gap in the numbering wherever records were overwritten.

Top module: `wake_history_log`

## Requirements
- R1: After reset, the fill count, record-valid, overflow flag and lost counter are all zero; the first captured record carries sequence number 0.
- R2: A captured record holds the source code (0 bus, 1 local, 2 timed, 3 spare), the mode before and the mode after (0 Normal, 1 Standby, 2 Sleep, 3 Forced-sleep), exactly as presented with the capture strobe.
- R3: The timestamp counter is zero in the first cycle after reset release and increments by one every clock. A record's timestamp equals the counter value in the cycle the capture strobe is sampled.
- R4: Records are presented oldest-first; each accepted pop exposes the next older-to-newer record.
- R5: The fill count rises by one per capture and falls by one per accepted pop. A pop while the fill count is zero is ignored and leaves the count at zero.
- R6: A capture while full, with no pop, overwrites the oldest record and keeps the fill count at DEPTH. It sets the overflow flag, which stays set until reset, and increments the lost counter, which saturates at its maximum.
- R7: The sequence number advances by one on every capture, including overwriting ones, so the sequence numbers of the remaining records show the gap.
- R8: A capture and a pop in the same cycle are both served. When full, no record is lost and the lost counter is unchanged. When empty, the pop is ignored and the new record is kept.
- R9: A record and its updated fill count become visible together in the cycle after the capture edge, with all fields present at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Capture strobe, one record per asserted cycle |
| evtSource | input | 2 | Wake source code |
| evtModeBefore | input | 2 | Power mode before the transition |
| evtModeAfter | input | 2 | Power mode after the transition |
| popReq | input | 1 | Discard the presented record |
| recValid | output | 1 | A record is presented |
| recSeq | output | SEQ_W | Sequence number of the presented record |
| recStamp | output | TS_W | Timestamp of the presented record |
| recSource | output | 2 | Source code of the presented record |
| recModeBefore | output | 2 | Mode before, presented record |
| recModeAfter | output | 2 | Mode after, presented record |
| fillCount | output | $clog2(DEPTH+1) | Number of stored records |
| overflowFlag | output | 1 | Sticky: a record was overwritten |
| lostCount | output | LOST_W | Overwritten records, saturating |

## Verification
The assertions check on every cycle the properties that hold locally:
- the fill count never exceeds the depth;
- a pop on an empty store leaves it empty;
- the overflow flag is sticky;
- a full store that sees a capture and a pop together keeps its count and its loss counter;
- the sequence counter steps once per capture.

Only the scenarios in the bench can show the following:
- that record contents survive intact and come back oldest-first;
- that timestamps match the cycle of capture;
- that the overwritten records are exactly the oldest ones, leaving the expected gap in numbering.

// File: rtl/wlog_pkg.sv
package wlog_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_SLEEP   = 2'd2,
    MODE_FORCED  = 2'd3
  } modeT;

  typedef enum logic [1:0] {
    SRC_BUS   = 2'd0,
    SRC_LOCAL = 2'd1,
    SRC_TIMED = 2'd2,
    SRC_SPARE = 2'd3
  } srcT;

  // Strobes from control to datapath
  typedef struct packed {
    logic write;      // store one record at the write slot
    logic advanceRd;  // retire the oldest slot
  } strobeT;

endpackage

// File: rtl/wlog_ctrl.sv
module wlog_ctrl
  import wlog_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LOST_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic              popReq,
  output strobeT            strobe,
  output logic              recValid,
  output logic [CNT_W-1:0]  fillCount,
  output logic              overflowFlag,
  output logic [LOST_W-1:0] lostCount
);

  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  logic isFull, isEmpty, popTake, dropOld;

  assign isFull   = (fillCount == FULL_CNT);
  assign isEmpty  = (fillCount == '0);
  assign recValid = !isEmpty;
  assign popTake  = popReq && !isEmpty;
  assign dropOld  = evtValid && isFull && !popTake;

  always_comb begin
    strobe           = '0;
    strobe.write     = evtValid;
    strobe.advanceRd = popTake || dropOld;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      unique case ({evtValid, popTake})
        2'b10:   if (!isFull) fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowFlag <= 1'b0;
      lostCount    <= '0;
    end else if (dropOld) begin
      overflowFlag <= 1'b1;
      if (lostCount != LOST_MAX) lostCount <= lostCount + 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_CNT); // R5
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !evtValid && fillCount == '0) |=> fillCount == '0); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag); // R6
  AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && popReq && fillCount == FULL_CNT)
      |=> (fillCount == FULL_CNT) && $stable(lostCount)); // R8

endmodule

// File: rtl/wlog_dpath.sv
module wlog_dpath
  import wlog_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TS_W  = 16,
  parameter int SEQ_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic [1:0]       evtSource,
  input  logic [1:0]       evtModeBefore,
  input  logic [1:0]       evtModeAfter,
  output logic [SEQ_W-1:0] recSeq,
  output logic [TS_W-1:0]  recStamp,
  output logic [1:0]       recSource,
  output logic [1:0]       recModeBefore,
  output logic [1:0]       recModeAfter
);

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [TS_W-1:0]  stamp;
    logic [1:0]       src;
    logic [1:0]       modeBefore;
    logic [1:0]       modeAfter;
  } recT;

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  logic [TS_W-1:0]  tsCnt;
  logic [SEQ_W-1:0] seqCnt;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  recT              newRec, headRec;
  recT              slots [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCnt <= '0;
      wrPtr  <= '0;
      rdPtr  <= '0;
    end else begin
      if (strobe.write) begin
        seqCnt <= seqCnt + 1'b1;
        wrPtr  <= nextIdx(wrPtr);
      end
      if (strobe.advanceRd) rdPtr <= nextIdx(rdPtr);
    end
  end

  always_comb begin
    newRec.seq        = seqCnt;
    newRec.stamp      = tsCnt;
    newRec.src        = evtSource;
    newRec.modeBefore = evtModeBefore;
    newRec.modeAfter  = evtModeAfter;
  end

  // One register per slot; a whole record is written in one edge
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         slots[g] <= '0;
      else if (strobe.write && wrPtr == PTR_W'(g))       slots[g] <= newRec;
    end
  end

  assign headRec       = slots[rdPtr];
  assign recSeq        = headRec.seq;
  assign recStamp      = headRec.stamp;
  assign recSource     = headRec.src;
  assign recModeBefore = headRec.modeBefore;
  assign recModeAfter  = headRec.modeAfter;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |=> seqCnt == SEQ_W'($past(seqCnt) + 1'b1)); // R7
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.write |=> $stable(seqCnt)); // R7
  AST_RD_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advanceRd && DEPTH > 1) |=> rdPtr != $past(rdPtr)); // R4

endmodule

// File: rtl/wake_history_log.sv
module wake_history_log
  import wlog_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TS_W   = 16,
  parameter int SEQ_W  = 8,
  parameter int LOST_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [1:0]        evtSource,
  input  logic [1:0]        evtModeBefore,
  input  logic [1:0]        evtModeAfter,
  input  logic              popReq,
  output logic              recValid,
  output logic [SEQ_W-1:0]  recSeq,
  output logic [TS_W-1:0]   recStamp,
  output logic [1:0]        recSource,
  output logic [1:0]        recModeBefore,
  output logic [1:0]        recModeAfter,
  output logic [CNT_W-1:0]  fillCount,
  output logic              overflowFlag,
  output logic [LOST_W-1:0] lostCount
);

  strobeT strobe;

  wlog_ctrl #(.DEPTH(DEPTH), .LOST_W(LOST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .popReq(popReq),
    .strobe(strobe), .recValid(recValid), .fillCount(fillCount),
    .overflowFlag(overflowFlag), .lostCount(lostCount)
  );

  wlog_dpath #(.DEPTH(DEPTH), .TS_W(TS_W), .SEQ_W(SEQ_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evtSource(evtSource), .evtModeBefore(evtModeBefore),
    .evtModeAfter(evtModeAfter),
    .recSeq(recSeq), .recStamp(recStamp), .recSource(recSource),
    .recModeBefore(recModeBefore), .recModeAfter(recModeAfter)
  );

endmodule

// File: tb/wake_history_log_test.sv
`timescale 1ns/100ps
module wake_history_log_test;
  localparam int DEPTH = 8, TS_W = 16, SEQ_W = 8, LOST_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic evtValid = 1'b0, popReq = 1'b0;
  logic [1:0] evtSource = '0, evtModeBefore = '0, evtModeAfter = '0;
  logic recValid, overflowFlag;
  logic [SEQ_W-1:0] recSeq;
  logic [TS_W-1:0] recStamp;
  logic [1:0] recSource, recModeBefore, recModeAfter;
  logic [CNT_W-1:0] fillCount;
  logic [LOST_W-1:0] lostCount;

  wake_history_log #(.DEPTH(DEPTH), .TS_W(TS_W), .SEQ_W(SEQ_W), .LOST_W(LOST_W)) uut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtSource(evtSource),
    .evtModeBefore(evtModeBefore), .evtModeAfter(evtModeAfter), .popReq(popReq),
    .recValid(recValid), .recSeq(recSeq), .recStamp(recStamp), .recSource(recSource),
    .recModeBefore(recModeBefore), .recModeAfter(recModeAfter), .fillCount(fillCount),
    .overflowFlag(overflowFlag), .lostCount(lostCount)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int seq; int stamp; int src; int mb; int ma;
  } expT;

  expT expQ[$];
  int  testCount = 0, failCount = 0;
  int  nextSeq = 0, expLost = 0;
  bit  expOvf = 1'b0;
  int  tbTs = 0;

  always @(posedge clk or negedge rstN)
    if (!rstN) tbTs <= 0; else tbTs <= (tbTs + 1) % (1 << TS_W);

  task automatic check(input string req, input string what, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare every visible output with the scoreboard
  task automatic checkState(input string req);
    check(req, "fillCount", int'(fillCount), expQ.size());
    check(req, "recValid", int'(recValid), (expQ.size() > 0) ? 1 : 0);
    check(req, "overflowFlag", int'(overflowFlag), int'(expOvf));
    check(req, "lostCount", int'(lostCount), expLost);
    if (expQ.size() > 0) begin
      check(req, "recSeq", int'(recSeq), expQ[0].seq % (1 << SEQ_W));
      check(req, "recStamp", int'(recStamp), expQ[0].stamp);
      check(req, "recSource", int'(recSource), expQ[0].src);
      check(req, "recModeBefore", int'(recModeBefore), expQ[0].mb);
      check(req, "recModeAfter", int'(recModeAfter), expQ[0].ma);
    end
  endtask

  // Driver: called at a negedge, applies one cycle of stimulus
  task automatic drive(input bit cap, input int src, input int mb, input int ma, input bit pop);
    expT e;
    evtValid = cap; popReq = pop;
    evtSource = 2'(src); evtModeBefore = 2'(mb); evtModeAfter = 2'(ma);
    if (pop && expQ.size() > 0) void'(expQ.pop_front());
    if (cap) begin
      e.seq = nextSeq; e.stamp = tbTs; e.src = src; e.mb = mb; e.ma = ma;
      nextSeq++;
      expQ.push_back(e);
      if (expQ.size() > DEPTH) begin
        void'(expQ.pop_front());
        expLost++;
        expOvf = 1'b1;
      end
    end
    @(negedge clk);
    evtValid = 1'b0; popReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1");

    // R9: record absent before the edge, whole afterwards
    evtValid = 1'b1; evtSource = 2'd1; evtModeBefore = 2'd2; evtModeAfter = 2'd0;
    check("R9", "recValid before edge", int'(recValid), 0);
    evtValid = 1'b0;
    drive(1, 1, 2, 0, 0);
    check("R1", "first seq", int'(recSeq), 0);
    checkState("R9");
    repeat (2) @(negedge clk);
    drive(1, 0, 3, 1, 0);
    drive(1, 2, 2, 0, 0);
    check("R5", "fill after three", int'(fillCount), 3);
    checkState("R2");
    // R3 / R4: pop oldest-first, checking each head
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 0, 0, 1);
      checkState("R4");
    end
    checkState("R3");
    // R5: pop while empty is ignored
    drive(0, 0, 0, 0, 1);
    checkState("R5");

    // R6 / R7: overfill by three
    for (int i = 0; i < DEPTH + 3; i++) drive(1, i % 4, i % 4, (i + 1) % 4, 0);
    check("R6", "lostCount", int'(lostCount), 3);
    check("R6", "overflowFlag", int'(overflowFlag), 1);
    check("R7", "head seq after gap", int'(recSeq), 3 + 3);
    checkState("R6");

    // R8: capture and pop together while full
    drive(1, 2, 1, 3, 1);
    check("R8", "fill stays full", int'(fillCount), DEPTH);
    checkState("R8");

    // Drain and check order, then simultaneous on empty
    for (int i = 0; i < DEPTH; i++) begin
      drive(0, 0, 0, 0, 1);
      checkState("R4");
    end
    drive(1, 3, 3, 2, 1);
    check("R8", "empty both keeps record", int'(fillCount), 1);
    checkState("R8");
    drive(0, 0, 0, 0, 1);
    checkState("R6");
    check("R7", "next seq continues", nextSeq, 3 + DEPTH + 3 + 2);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule